// File: doc/BRIEF.md
# Character Pattern Memory with Instruction/Data Register Port

This block holds the glyph patterns of eight user-defined characters for a character display controller. Each character is eight rows tall and each row is five pixels wide, so the store has 64 row locations. The host cannot address these locations directly. It sees two byte-wide registers, selected by a single address bit: an instruction register and a data register.

To reach a row, the host first writes an address-load command to the instruction register. The row address is the character number times eight plus the row number. The host then streams data-register writes or reads. After each data access the internal row pointer steps forward by one. A whole character can therefore be defined with one command followed by eight data writes. Any row can be read back by loading its address and then reading the data register.

The control path decodes each host access into one named operation: NONE, LOAD, STORE, FETCH or DROP. A unique case on that operation drives the pointer register and the memory.

Top module: `cgram_port`

## Requirements
- R1: `reg_sel` = 0 addresses the instruction register and `reg_sel` = 1 addresses the data register. Only data-register accesses touch the pattern memory.
- R2: A write to the instruction register whose bits [7:6] equal 2'b01 loads the row pointer with bits [5:0] of the written byte.
- R3: A write to the data register stores bits [4:0] of the byte at the current row pointer. The pointer then increases by one.
- R4: A read of the data register places {3'b000, stored row} on `rd_data` at the first rising edge after the strobe. The pointer then increases by one. Bits [7:5] of `rd_data` are always zero.
- R5: An instruction-register write whose bits [7:6] are not 2'b01 leaves the row pointer unchanged.
- R6: The row pointer wraps from 63 to 0 when it advances.
- R7: `rd_data` keeps its value in every cycle without a data-register read. A read strobe with `reg_sel` = 0 is ignored and does not move the pointer.
- R8: After reset the row pointer is 0, all 64 rows read as zero and `rd_data` is zero.
- R9: If write and read strobes are both high in the same cycle, the write is performed and the read is dropped. `rd_data` holds and the pointer advances only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 selects the instruction register, 1 selects the data register |
| wr_stb | input | 1 | Write strobe, one access per cycle it is high |
| rd_stb | input | 1 | Read strobe, one access per cycle it is high |
| wr_data | input | 8 | Byte written by the host |
| rd_data | output | 8 | Registered read data |

## Verification
Every access takes effect at the rising edge that samples its strobe. Pointer loads and advances are visible to the very next access, and read data appears on `rd_data` right after that same edge. The bench drives each access on a falling edge. It updates its behavioural model as of the following rising edge and compares `rd_data` at the next falling edge, once per clock. Pointer effects such as loads, ignored commands and wraps are observed one access later, through the value the following data read returns.

// File: rtl/cgram_pkg.sv
package cgram_pkg;
    localparam int ROWS_PER_CHAR = 8;
    localparam int NUM_CHARS     = 8;
    localparam int DEPTH         = ROWS_PER_CHAR * NUM_CHARS;
    localparam int PTR_W         = $clog2(DEPTH);
    localparam int BYTE_W        = 8;
    localparam int PIX_W         = 5;
    localparam int CMD_W         = BYTE_W - PTR_W;
    localparam logic [CMD_W-1:0] LOAD_CODE = CMD_W'(1);

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_STORE,
        OP_FETCH,
        OP_DROP
    } op_e;
endpackage

// File: rtl/cgram_decode.sv
module cgram_decode
    import cgram_pkg::*;
(
    input  logic              reg_sel,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [BYTE_W-1:0] wr_data,
    output op_e               op
);
    always_comb begin
        unique case ({wr_stb, rd_stb, reg_sel})
            3'b100, 3'b110: op = (wr_data[BYTE_W-1:PTR_W] == LOAD_CODE) ? OP_LOAD : OP_DROP;
            3'b101, 3'b111: op = OP_STORE;
            3'b011:         op = OP_FETCH;
            default:        op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/cgram_ctrl.sv
module cgram_ctrl
    import cgram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [PTR_W-1:0]  ptr
);
    logic [PTR_W-1:0] ptr_nxt;

    always_comb begin
        unique case (op)
            OP_LOAD:            ptr_nxt = wr_data[PTR_W-1:0];
            OP_STORE, OP_FETCH: ptr_nxt = ptr + PTR_W'(1);
            default:            ptr_nxt = ptr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_nxt;
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (ptr == $past(wr_data[PTR_W-1:0])));
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STORE || op == OP_FETCH) |=> (ptr == PTR_W'($past(ptr) + 1)));
    p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DROP) |=> $stable(ptr));
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_STORE || op == OP_FETCH) && ptr == PTR_W'(DEPTH-1)) |=> (ptr == '0));
endmodule

// File: rtl/cgram_store.sv
module cgram_store
    import cgram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data
);
    logic [PIX_W-1:0] rows [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  rows[g] <= '0;
            else if (op == OP_STORE && ptr == PTR_W'(g)) rows[g] <= wr_data[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              rd_data <= '0;
        else if (op == OP_FETCH) rd_data <= {{(BYTE_W-PIX_W){1'b0}}, rows[ptr]};
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_FETCH) |=> $stable(rd_data));
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BYTE_W-1:PIX_W] == '0);
endmodule

// File: rtl/cgram_port.sv
module cgram_port
    import cgram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data
);
    op_e              op;
    logic [PTR_W-1:0] ptr;

    cgram_decode u_decode (
        .reg_sel (reg_sel),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .wr_data (wr_data),
        .op      (op)
    );

    cgram_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .wr_data (wr_data),
        .ptr     (ptr)
    );

    cgram_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .ptr     (ptr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    p_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_sel && rd_stb && !wr_stb) |=> $stable(rd_data));
    p_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && rd_stb && wr_stb) |=> $stable(rd_data));
endmodule

// File: tb/cgram_port_tb.sv
module cgram_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       wr_stb = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    int m_mem [64];
    int m_ptr = 0;
    int m_rd = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cgram_port dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic check(input string tag, input int exp);
        checks++;
        if (int'(rd_data) !== exp) begin
            failures++;
            $display("FAIL %s rd_data actual=%0h expected=%0h", tag, rd_data, exp);
        end
    endtask

    task automatic access(input string tag, input bit s, input bit w, input bit r, input int d);
        @(negedge clk);
        reg_sel = s; wr_stb = w; rd_stb = r; wr_data = 8'(d);
        @(posedge clk);
        if (w && !s) begin
            if (((d >> 6) & 3) == 1) m_ptr = d & 63;
        end else if (w && s) begin
            m_mem[m_ptr] = d & 31; m_ptr = (m_ptr + 1) % 64;
        end else if (r && s) begin
            m_rd = m_mem[m_ptr]; m_ptr = (m_ptr + 1) % 64;
        end
        @(negedge clk);
        reg_sel = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
        check(tag, m_rd);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        foreach (m_mem[i]) m_mem[i] = 0;
        repeat (3) @(negedge clk);
        check("R8 reset rd_data", 0);
        rst_n = 1'b1;
        // R8: pointer starts at 0, every row cleared
        for (int i = 0; i < 64; i++) access("R8 cleared row", 1, 0, 1, 0);
        // R1 R2 R3: define character 2 then read it back (R4)
        access("R2 load char2", 0, 1, 0, 8'h40 + 16);
        for (int i = 0; i < 8; i++) access("R3 store row", 1, 1, 0, 8'hA0 + i * 3);
        access("R2 reload char2", 0, 1, 0, 8'h40 + 16);
        for (int i = 0; i < 8; i++) access("R4 fetch row", 1, 0, 1, 0);
        // R4: upper bits read as zero
        access("R2 load 5", 0, 1, 0, 8'h45);
        access("R3 store ff", 1, 1, 0, 8'hFF);
        access("R2 load 5", 0, 1, 0, 8'h45);
        access("R4 upper zero", 1, 0, 1, 0);
        // R5: non-matching commands leave pointer
        access("R2 load 17", 0, 1, 0, 8'h40 + 17);
        access("R5 ignore 80", 0, 1, 0, 8'h80);
        access("R5 ignore 3f", 0, 1, 0, 8'h3F);
        access("R5 ignore c5", 0, 1, 0, 8'hC5);
        access("R5 fetch 17", 1, 0, 1, 0);
        // R6: wrap 63 -> 0
        access("R2 load 63", 0, 1, 0, 8'h7F);
        access("R6 store 63", 1, 1, 0, 8'h11);
        access("R6 store 0", 1, 1, 0, 8'h0E);
        access("R2 load 63", 0, 1, 0, 8'h7F);
        access("R6 fetch 63", 1, 0, 1, 0);
        access("R6 fetch 0", 1, 0, 1, 0);
        // R7: idle holds, read on instruction register ignored
        for (int i = 0; i < 4; i++) access("R7 idle hold", 0, 0, 0, 0);
        access("R7 instr read", 0, 0, 1, 0);
        access("R7 after instr read", 1, 0, 1, 0);
        // R9: simultaneous strobes
        access("R2 load 30", 0, 1, 0, 8'h40 + 30);
        access("R9 both", 1, 1, 1, 8'h15);
        access("R2 load 30", 0, 1, 0, 8'h40 + 30);
        access("R9 fetch 30", 1, 0, 1, 0);
        access("R9 fetch 31", 1, 0, 1, 0);
        // Full sweep of all characters
        access("R2 load 0", 0, 1, 0, 8'h40);
        for (int i = 0; i < 64; i++) access("R3 sweep store", 1, 1, 0, (i * 7 + 3) & 255);
        for (int i = 0; i < 64; i++) access("R4 sweep fetch", 1, 0, 1, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule